// File: doc/BRIEF.md
# Set-Associative Line Cache with Least-Recently-Used Replacement

This block keeps whole cache lines together with their tags, and its tag lookup runs in parallel with the line data array. Each clock cycle it accepts one command, taken from four control strobes. The commands are a plain lookup that reads a line, a lookup that overwrites a line, and either lookup combined with invalidation of the line it hit. A fill command installs a new line in place of a victim way. The results come back one cycle later on registered outputs: a hit flag, a miss flag, the line contents, and the address of the line that a fill pushed out.

The address is a line address only, with no word or byte offset. Its low bits select a set and the remaining bits form the tag. When the number of sets is one, the set field is empty and the cache is fully associative. The data array reads before it writes. A write or a fill therefore returns the content the line held before the command. Within a set, a fill chooses the lowest-numbered empty way. If the set has no empty way, the fill chooses the least recently used way.

Top module: `assoc_line_cache`

## Requirements
- R1: A synchronous reset marks every way invalid. It leaves hit and miss low, rd_line zero and evicted_addr zero, and it sets every stored tag to zero.
- R2: Commands are decoded as follows. lookup_req=1 starts a request, whatever evict_req is: write_sel=0 reads and write_sel=1 writes. lookup_req=0 with drop_line=0 and evict_req=1 is a fill, whatever write_sel is. Every other combination does nothing.
- R3: In the cycle after a request, exactly one of hit and miss is high. In the cycle after any other command, both are low.
- R4: A read request that hits puts the stored line on rd_line in the next cycle.
- R5: A write request that hits stores wr_line into the matching way. In the next cycle rd_line shows the line's previous content.
- R6: drop_line=1 on a request that hits performs the read or write first and then clears the way's valid bit. Later requests to that address miss.
- R7: A request that misses changes no line, no tag, no valid bit and no recency state, and rd_line keeps its value.
- R8: A fill writes wr_line and the new tag into the victim way of the addressed set and marks the way valid. In the next cycle rd_line carries the victim's former content, and evicted_addr carries the victim's former tag shifted up by the set-field width, ORed with the set index.
- R9: The victim is the lowest-numbered invalid way of the set. If the set has no invalid way, the victim is its least recently used way. A hit or a fill makes the way it accessed the most recently used. After reset, recency order is way 0 newest to way WAYS-1 oldest.
- R10: The set index is the low log2(LINES/WAYS) bits of line_addr, and the tag is the remaining upper bits. Sets are independent of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lookup_req | input | 1 | Request strobe |
| write_sel | input | 1 | 1 = write request, 0 = read request |
| drop_line | input | 1 | Invalidate the hit way after the access |
| evict_req | input | 1 | Fill strobe |
| line_addr | input | ADDR_W | Line address (set index in the low bits) |
| wr_line | input | LINE_W | Line data for writes and fills |
| rd_line | output | LINE_W | Line read or displaced, one cycle later |
| hit | output | 1 | Request hit, one cycle later |
| miss | output | 1 | Request missed, one cycle later |
| evicted_addr | output | ADDR_W | Address of the displaced line, one cycle after a fill |

## Verification
Every result of this block appears one clock edge after the command that caused it, and stays there until the next edge. This covers hit, miss, rd_line and evicted_addr. The bench drives each command on a falling edge and removes it just after the rising edge that samples it. It then reads the outputs on the following falling edge, which keeps every check in the single cycle where the result is due. Commands that must leave state unchanged, such as a write miss or an illegal strobe mix, are followed by a read request. That read's one-cycle-later result shows whether any line was changed.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_READ,
    CMD_WRITE,
    CMD_READ_DROP,
    CMD_WRITE_DROP,
    CMD_FILL
  } cache_cmd_e;

  // R2: request strobe wins; fill only without invalidate
  function automatic cache_cmd_e decode_cmd(input logic req, input logic wr,
                                            input logic drop, input logic fill);
    if (req) begin
      if (wr) return drop ? CMD_WRITE_DROP : CMD_WRITE;
      else    return drop ? CMD_READ_DROP  : CMD_READ;
    end else if (fill && !drop) begin
      return CMD_FILL;
    end
    return CMD_NOP;
  endfunction

endpackage

// File: rtl/way_recency.sv
module way_recency #(
  parameter int LINES = 32,
  parameter int WAYS  = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [((LINES/WAYS) > 1 ? $clog2(LINES/WAYS) : 1)-1:0] set_idx,
  input  logic                          touch_en,
  input  logic [$clog2(WAYS)-1:0]       touch_way,
  output logic [$clog2(WAYS)-1:0]       oldest_way
);
  localparam int SETS  = LINES / WAYS;
  localparam int IDX_W = SETS > 1 ? $clog2(SETS) : 1;
  localparam int WAY_W = $clog2(WAYS);
  localparam int LI_W  = $clog2(LINES);

  // age 0 = most recent, WAYS-1 = least recent; ages of a set form a permutation
  logic [WAY_W-1:0] age [LINES];
  logic [WAY_W-1:0] touched_age;

  function automatic logic [LI_W-1:0] line_of(input logic [IDX_W-1:0] s, input int w);
    return LI_W'(int'(s) * WAYS + w);
  endfunction

  assign touched_age = age[line_of(set_idx, int'(touch_way))];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) age[i] <= WAY_W'(i % WAYS);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age[line_of(set_idx, w)] <= '0;
        else if (age[line_of(set_idx, w)] < touched_age)
          age[line_of(set_idx, w)] <= age[line_of(set_idx, w)] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age[line_of(set_idx, w)] == WAY_W'(WAYS - 1)) oldest_way = WAY_W'(w);
  end

endmodule

// File: rtl/tag_store.sv
module tag_store #(
  parameter int LINES = 32,
  parameter int WAYS  = 32,
  parameter int TAG_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [((LINES/WAYS) > 1 ? $clog2(LINES/WAYS) : 1)-1:0] set_idx,
  input  logic [TAG_W-1:0]              look_tag,
  input  logic                          fill_en,
  input  logic [$clog2(WAYS)-1:0]       fill_way,
  input  logic                          drop_en,
  input  logic [$clog2(WAYS)-1:0]       drop_way,
  input  logic [$clog2(WAYS)-1:0]       peek_way,
  output logic                          hit_any,
  output logic [$clog2(WAYS)-1:0]       hit_way,
  output logic [WAYS-1:0]               valid_set,
  output logic [TAG_W-1:0]              peek_tag
);
  localparam int SETS  = LINES / WAYS;
  localparam int IDX_W = SETS > 1 ? $clog2(SETS) : 1;
  localparam int WAY_W = $clog2(WAYS);
  localparam int LI_W  = $clog2(LINES);

  logic [TAG_W-1:0] tags [LINES];
  logic [LINES-1:0] valid;
  logic [WAYS-1:0]  match_vec;

  function automatic logic [LI_W-1:0] line_of(input logic [IDX_W-1:0] s, input int w);
    return LI_W'(int'(s) * WAYS + w);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
      for (int i = 0; i < LINES; i++) tags[i] <= '0;
    end else begin
      if (fill_en) begin
        tags[line_of(set_idx, int'(fill_way))]  <= look_tag;
        valid[line_of(set_idx, int'(fill_way))] <= 1'b1;
      end
      if (drop_en) valid[line_of(set_idx, int'(drop_way))] <= 1'b0;
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      valid_set[w] = valid[line_of(set_idx, w)];
      match_vec[w] = valid_set[w] && (tags[line_of(set_idx, w)] == look_tag);
    end
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match_vec[w]) hit_way = WAY_W'(w);
  end

  assign hit_any  = |match_vec;
  assign peek_tag = tags[line_of(set_idx, int'(peek_way))];

endmodule

// File: rtl/victim_pick.sv
module victim_pick #(
  parameter int WAYS = 32
) (
  input  logic [WAYS-1:0]         valid_set,
  input  logic [$clog2(WAYS)-1:0] oldest_way,
  output logic [$clog2(WAYS)-1:0] victim_way
);
  localparam int WAY_W = $clog2(WAYS);

  // R9: lowest empty way beats the least recent way
  always_comb begin
    victim_way = oldest_way;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_set[w]) victim_way = WAY_W'(w);
  end

endmodule

// File: rtl/line_store.sv
module line_store #(
  parameter int LINES  = 32,
  parameter int WAYS   = 32,
  parameter int LINE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [((LINES/WAYS) > 1 ? $clog2(LINES/WAYS) : 1)-1:0] set_idx,
  input  logic [$clog2(WAYS)-1:0]       way,
  input  logic                          rd_en,
  input  logic                          wr_en,
  input  logic [LINE_W-1:0]             wr_data,
  output logic [LINE_W-1:0]             rd_data
);
  localparam int LI_W = $clog2(LINES);

  logic [LINE_W-1:0] mem [LINES];
  logic [LI_W-1:0]   slot;

  assign slot = LI_W'(int'(set_idx) * WAYS + int'(way));

  // read-first: the registered read takes the content before this edge's write
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mem[slot];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[slot] <= wr_data;
  end

endmodule

// File: rtl/assoc_line_cache.sv
module assoc_line_cache
  import cache_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int WAYS   = 32,
  parameter int ADDR_W = 8,
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lookup_req,
  input  logic              write_sel,
  input  logic              drop_line,
  input  logic              evict_req,
  input  logic [ADDR_W-1:0] line_addr,
  input  logic [LINE_W-1:0] wr_line,
  output logic [LINE_W-1:0] rd_line,
  output logic              hit,
  output logic              miss,
  output logic [ADDR_W-1:0] evicted_addr
);
  localparam int SETS  = LINES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int IDX_W = SET_W > 0 ? SET_W : 1;
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SET_W;
  localparam logic [ADDR_W-1:0] SET_MASK = ADDR_W'((1 << SET_W) - 1);

  // R10: address split
  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return IDX_W'(a & SET_MASK);
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return TAG_W'(a >> SET_W);
  endfunction

  // R8: rebuild a line address from stored tag and set
  function automatic logic [ADDR_W-1:0] join_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] s);
    return (ADDR_W'(t) << SET_W) | (ADDR_W'(s) & SET_MASK);
  endfunction

  cache_cmd_e       cmd;
  logic             is_req, is_write, is_drop, do_fill;
  logic             lookup_hit, lookup_miss;
  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] look_tag, victim_tag;
  logic             tag_hit;
  logic [WAY_W-1:0] hit_way, victim_way, oldest_way, access_way;
  logic [WAYS-1:0]  valid_set;
  logic             touch_en, line_we, line_re;

  assign cmd      = decode_cmd(lookup_req, write_sel, drop_line, evict_req);
  assign is_req   = (cmd == CMD_READ) || (cmd == CMD_WRITE) ||
                    (cmd == CMD_READ_DROP) || (cmd == CMD_WRITE_DROP);
  assign is_write = (cmd == CMD_WRITE) || (cmd == CMD_WRITE_DROP);
  assign is_drop  = (cmd == CMD_READ_DROP) || (cmd == CMD_WRITE_DROP);
  assign do_fill  = (cmd == CMD_FILL);

  assign set_idx  = set_of(line_addr);
  assign look_tag = tag_of(line_addr);

  assign lookup_hit  = is_req && tag_hit;
  assign lookup_miss = is_req && !tag_hit;
  assign access_way  = do_fill ? victim_way : hit_way;
  assign touch_en    = lookup_hit || do_fill;
  assign line_we     = (lookup_hit && is_write) || do_fill;
  assign line_re     = lookup_hit || do_fill;

  tag_store #(.LINES(LINES), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .set_idx   (set_idx),
    .look_tag  (look_tag),
    .fill_en   (do_fill),
    .fill_way  (victim_way),
    .drop_en   (lookup_hit && is_drop),
    .drop_way  (hit_way),
    .peek_way  (victim_way),
    .hit_any   (tag_hit),
    .hit_way   (hit_way),
    .valid_set (valid_set),
    .peek_tag  (victim_tag)
  );

  way_recency #(.LINES(LINES), .WAYS(WAYS)) u_age (
    .clk        (clk),
    .rst        (rst),
    .set_idx    (set_idx),
    .touch_en   (touch_en),
    .touch_way  (access_way),
    .oldest_way (oldest_way)
  );

  victim_pick #(.WAYS(WAYS)) u_victim (
    .valid_set  (valid_set),
    .oldest_way (oldest_way),
    .victim_way (victim_way)
  );

  line_store #(.LINES(LINES), .WAYS(WAYS), .LINE_W(LINE_W)) u_data (
    .clk     (clk),
    .rst     (rst),
    .set_idx (set_idx),
    .way     (access_way),
    .rd_en   (line_re),
    .wr_en   (line_we),
    .wr_data (wr_line),
    .rd_data (rd_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit          <= 1'b0;
      miss         <= 1'b0;
      evicted_addr <= '0;
    end else begin
      hit  <= lookup_hit;
      miss <= lookup_miss;
      if (do_fill) evicted_addr <= join_addr(victim_tag, set_idx);
    end
  end

endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
  parameter int ADDR_W = 8,
  parameter int LINE_W = 8,
  parameter int WAYS   = 32,
  parameter int SET_W  = 0
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    is_req,
  input logic                    lookup_hit,
  input logic                    do_fill,
  input logic [ADDR_W-1:0]       line_addr,
  input logic [WAYS-1:0]         valid_set,
  input logic [$clog2(WAYS)-1:0] victim_way,
  input logic                    hit,
  input logic                    miss,
  input logic [LINE_W-1:0]       rd_line,
  input logic [ADDR_W-1:0]       evicted_addr
);
  localparam logic [ADDR_W-1:0] SET_MASK = ADDR_W'((1 << SET_W) - 1);

  // R3
  req_answer_chk: assert property (@(posedge clk) disable iff (rst)
    is_req |=> (hit ^ miss));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !is_req |=> (!hit && !miss));

  // R7
  miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (is_req && !lookup_hit) |=> $stable(rd_line));

  // R10
  evict_set_chk: assert property (@(posedge clk) disable iff (rst)
    do_fill |=> (((evicted_addr ^ $past(line_addr)) & SET_MASK) == '0));

  // R9
  free_first_chk: assert property (@(posedge clk) disable iff (rst)
    (do_fill && !(&valid_set)) |-> !valid_set[victim_way]);

endmodule

bind assoc_line_cache cache_chk #(
  .ADDR_W (ADDR_W),
  .LINE_W (LINE_W),
  .WAYS   (WAYS),
  .SET_W  (SET_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .is_req       (is_req),
  .lookup_hit   (lookup_hit),
  .do_fill      (do_fill),
  .line_addr    (line_addr),
  .valid_set    (valid_set),
  .victim_way   (victim_way),
  .hit          (hit),
  .miss         (miss),
  .rd_line      (rd_line),
  .evicted_addr (evicted_addr)
);

// File: tb/sim_assoc_line_cache.sv
`timescale 1ns/1ps
module sim_assoc_line_cache;
  // 8 lines, 4 ways -> 2 sets; set index = line_addr[0], tag = line_addr[7:1]
  localparam int LINES = 8, WAYS = 4, ADDR_W = 8, LINE_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lookup_req = 0, write_sel = 0, drop_line = 0, evict_req = 0;
  logic [ADDR_W-1:0] line_addr = '0;
  logic [LINE_W-1:0] wr_line = '0;
  logic [LINE_W-1:0] rd_line;
  logic hit, miss;
  logic [ADDR_W-1:0] evicted_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assoc_line_cache #(.LINES(LINES), .WAYS(WAYS), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u0 (
    .clk(clk), .rst(rst), .lookup_req(lookup_req), .write_sel(write_sel),
    .drop_line(drop_line), .evict_req(evict_req), .line_addr(line_addr),
    .wr_line(wr_line), .rd_line(rd_line), .hit(hit), .miss(miss),
    .evicted_addr(evicted_addr)
  );

  task automatic expect_val(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, act, exp);
    end
  endtask

  // one command, outputs sampled one cycle later on a falling edge
  task automatic issue(input logic r, input logic w, input logic d, input logic f,
                       input logic [7:0] a, input logic [15:0] data);
    @(negedge clk);
    lookup_req = r; write_sel = w; drop_line = d; evict_req = f;
    line_addr = a; wr_line = data;
    @(posedge clk);
    #1;
    lookup_req = 0; write_sel = 0; drop_line = 0; evict_req = 0;
    @(negedge clk);
  endtask

  task automatic read_hit(input string what, input logic [7:0] a, input logic [15:0] exp);
    issue(1, 0, 0, 0, a, 16'h0);
    expect_val({what, " hit"}, 32'(hit), 32'd1);
    expect_val({what, " data"}, 32'(rd_line), 32'(exp));
  endtask

  task automatic read_miss(input string what, input logic [7:0] a);
    issue(1, 0, 0, 0, a, 16'h0);
    expect_val({what, " miss"}, 32'(miss), 32'd1);
    expect_val({what, " no hit"}, 32'(hit), 32'd0);
  endtask

  task automatic t_reset;
    expect_val("R1 hit after reset", 32'(hit), 0);
    expect_val("R1 miss after reset", 32'(miss), 0);
    expect_val("R1 rd_line after reset", 32'(rd_line), 0);
    expect_val("R1 evicted_addr after reset", 32'(evicted_addr), 0);
    read_miss("R1 empty cache", 8'h10);
  endtask

  task automatic t_fill_and_read;
    issue(0, 0, 0, 1, 8'h10, 16'hA000);
    expect_val("R8 evict of empty way (reset tag)", 32'(evicted_addr), 32'h00);
    expect_val("R3 no hit after fill", 32'(hit), 0);
    expect_val("R3 no miss after fill", 32'(miss), 0);
    issue(0, 0, 0, 1, 8'h12, 16'hA001);
    issue(0, 0, 0, 1, 8'h14, 16'hA002);
    issue(0, 0, 0, 1, 8'h16, 16'hA003);
    read_hit("R4 read 0x10", 8'h10, 16'hA000);
    read_hit("R4 read 0x12", 8'h12, 16'hA001);
    read_hit("R4 read 0x14", 8'h14, 16'hA002);
    read_hit("R4 read 0x16", 8'h16, 16'hA003);
  endtask

  task automatic t_write_hit;
    issue(1, 1, 0, 0, 8'h12, 16'hBEEF);
    expect_val("R5 write hit flag", 32'(hit), 1);
    expect_val("R5 write returns old line", 32'(rd_line), 32'hA001);
    read_hit("R5 read back written", 8'h12, 16'hBEEF);
  endtask

  task automatic t_lru_evict;
    // recency after 10,12,14,16,12,12 touches: 0x10 oldest
    issue(0, 0, 0, 1, 8'h18, 16'h5188);
    expect_val("R9 LRU victim address", 32'(evicted_addr), 32'h10);
    expect_val("R8 evicted line content", 32'(rd_line), 32'hA000);
    read_miss("R8 evicted address gone", 8'h10);
    expect_val("R7 rd_line held on miss", 32'(rd_line), 32'hA000);
    read_hit("R8 new line present", 8'h18, 16'h5188);
  endtask

  task automatic t_invalidate;
    issue(1, 0, 1, 0, 8'h14, 16'h0);
    expect_val("R6 read-drop hit", 32'(hit), 1);
    expect_val("R6 read-drop data", 32'(rd_line), 32'hA002);
    read_miss("R6 dropped line misses", 8'h14);
    // 0x16 is the LRU valid way, but the freed way must win
    issue(0, 0, 0, 1, 8'h1A, 16'h1A1A);
    expect_val("R9 invalid way chosen first", 32'(evicted_addr), 32'h14);
    read_hit("R9 LRU line kept", 8'h16, 16'hA003);
  endtask

  task automatic t_write_miss;
    issue(1, 1, 0, 0, 8'h20, 16'hDEAD);
    expect_val("R7 write miss flag", 32'(miss), 1);
    expect_val("R7 write miss keeps rd_line", 32'(rd_line), 32'hA003);
    read_miss("R7 write miss installs nothing", 8'h20);
    read_hit("R7 other lines intact", 8'h18, 16'h5188);
  endtask

  task automatic t_write_drop;
    issue(1, 1, 1, 0, 8'h16, 16'h7777);
    expect_val("R6 write-drop hit", 32'(hit), 1);
    expect_val("R6 write-drop old data", 32'(rd_line), 32'hA003);
    read_miss("R6 write-dropped line misses", 8'h16);
    // fill with write_sel=1 must still fill (R2); victim is the freed way
    issue(0, 1, 0, 1, 8'h1C, 16'h1C1C);
    expect_val("R2 fill ignores write_sel", 32'(evicted_addr), 32'h16);
    expect_val("R6 data written before drop", 32'(rd_line), 32'h7777);
    read_hit("R2 filled line present", 8'h1C, 16'h1C1C);
  endtask

  task automatic t_set_index;
    issue(0, 0, 0, 1, 8'h11, 16'h1111);
    expect_val("R10 set 1 empty victim address", 32'(evicted_addr), 32'h01);
    read_hit("R10 set 1 line", 8'h11, 16'h1111);
    read_hit("R10 set 0 untouched", 8'h1A, 16'h1A1A);
    read_miss("R10 tag differs", 8'h13);
  endtask

  task automatic t_decode;
    issue(0, 0, 1, 1, 8'h13, 16'h3333);
    expect_val("R2 fill with drop is nop (hit)", 32'(hit), 0);
    expect_val("R2 fill with drop is nop (miss)", 32'(miss), 0);
    read_miss("R2 nothing installed", 8'h13);
    issue(1, 0, 0, 1, 8'h11, 16'h0);
    expect_val("R2 request wins over fill", 32'(hit), 1);
    expect_val("R2 request wins data", 32'(rd_line), 32'h1111);
    issue(0, 0, 0, 0, 8'h11, 16'h0);
    expect_val("R3 nop quiet hit", 32'(hit), 0);
    expect_val("R3 nop quiet miss", 32'(miss), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_fill_and_read();
    t_write_hit();
    t_lru_evict();
    t_invalidate();
    t_write_miss();
    t_write_drop();
    t_set_index();
    t_decode();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule